// File: doc/BRIEF.md
# Four-Mode Shift Word

A small storage word whose next value is picked, every rising clock edge, by a two-bit mode code. The word can keep its value, move one place toward its most significant end (taking a serial bit in at the bottom), move one place toward its least significant end, or take a full parallel word. When moving down, a separate control decides what enters the top bit. It is either a zero, for an unsigned shift, or a copy of the current top bit, which keeps the sign of a two's-complement value.

Each bit has its own four-way selector. The selector chooses between the bit's present value, the bit just below it, the bit just above it, and its bit of the parallel word. A small piece of boundary logic supplies the missing neighbours at the two ends of the word. A synchronous clear overrides every mode. All state changes happen on the rising edge of one free-running clock, and the clock is never gated.

Top module: `dual_shift_word`

## Requirements
- R1: When `clr` is 1 at a rising edge, `word_q` becomes all zeros after that edge, whatever `mode`, `arith_sel`, `ser_in` and `load_data` are.
- R2: With `clr` 0 and `mode` = 2'b00 (hold), `word_q` keeps its value across the edge.
- R3: With `clr` 0 and `mode` = 2'b01 (move up), bit i of `word_q` takes the old bit i-1 for i ≥ 1, and bit 0 takes `ser_in`.
- R4: With `clr` 0, `mode` = 2'b10 (move down) and `arith_sel` 0, bit i takes the old bit i+1 and the top bit becomes 0.
- R5: With `clr` 0, `mode` = 2'b10 and `arith_sel` 1, bit i takes the old bit i+1 and the top bit keeps its old value.
- R6: With `clr` 0 and `mode` = 2'b11 (load), `word_q` takes `load_data`.
- R7: Inputs that the selected mode does not use have no effect on the next value. `ser_in` matters only in mode 2'b01, `arith_sel` only in mode 2'b10, and `load_data` only in mode 2'b11.
- R8: `word_q` changes only at rising clock edges. Changing any input between edges leaves it unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, active high, overrides the mode |
| mode | input | 2 | 00 hold, 01 move up, 10 move down, 11 load |
| arith_sel | input | 1 | Top-bit fill for move down: 0 zero, 1 keep sign |
| ser_in | input | 1 | Bit entering at bit 0 on move up |
| load_data | input | WIDTH (4) | Parallel word for the load mode |
| word_q | output | WIDTH (4) | Present stored value |

## Verification
The sign-keeping down shift needs a stored word with its top bit set, and the ports have no direct way to put one there. It can also hide behind a zero fill whenever the top bit is already 0. The stimulus therefore loads every possible starting word through the load mode first. It then applies each mode with every combination of `arith_sel` and `ser_in` and several parallel words, so both fills are seen from negative and non-negative starts, and the unused inputs vary while the expected value stays fixed. The clear is also driven together with each mode to show that it wins, and inputs are changed in the middle of a cycle to show that the word waits for the edge.

// File: rtl/shift_word_pkg.sv
package shift_word_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_LOAD = 2'b11
    } step_mode_t;

    typedef struct packed {
        logic bottom_in;
        logic top_in;
    } edge_feed_t;

    function automatic logic down_fill(input logic keep_sign, input logic top_bit);
        return keep_sign ? top_bit : 1'b0;
    endfunction

endpackage

// File: rtl/shift_bit_cell.sv
module shift_bit_cell
    import shift_word_pkg::*;
(
    input  step_mode_t sel,
    input  logic       own_q,
    input  logic       below_q,
    input  logic       above_q,
    input  logic       par_bit,
    output logic       next_bit
);
    always_comb begin
        unique case (sel)
            MODE_HOLD: next_bit = own_q;
            MODE_UP:   next_bit = below_q;
            MODE_DOWN: next_bit = above_q;
            MODE_LOAD: next_bit = par_bit;
            default:   next_bit = own_q;
        endcase
    end
endmodule

// File: rtl/edge_feed_logic.sv
module edge_feed_logic
    import shift_word_pkg::*;
(
    input  logic       ser_bit,
    input  logic       keep_sign,
    input  logic       msb_now,
    output edge_feed_t feed
);
    always_comb begin
        feed.bottom_in = ser_bit;
        feed.top_in    = down_fill(keep_sign, msb_now);
    end
endmodule

// File: rtl/word_store.sv
module word_store #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [WIDTH-1:0] next_word,
    output logic [WIDTH-1:0] cur_word
);
    always_ff @(posedge clk) begin
        if (clr) cur_word <= '0;
        else     cur_word <= next_word;
    end
endmodule

// File: rtl/dual_shift_word.sv
module dual_shift_word
    import shift_word_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [1:0]       mode,
    input  logic             arith_sel,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] load_data,
    output logic [WIDTH-1:0] word_q
);
    localparam int TOP = WIDTH - 1;

    step_mode_t       sel;
    edge_feed_t       feed;
    logic [WIDTH-1:0] cur_word;
    logic [WIDTH-1:0] next_word;

    assign sel = step_mode_t'(mode);

    edge_feed_logic u_feed (
        .ser_bit   (ser_in),
        .keep_sign (arith_sel),
        .msb_now   (cur_word[TOP]),
        .feed      (feed)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic below_q;
        logic above_q;
        if (i == 0) begin : g_low
            assign below_q = feed.bottom_in;
        end else begin : g_low
            assign below_q = cur_word[i-1];
        end
        if (i == TOP) begin : g_high
            assign above_q = feed.top_in;
        end else begin : g_high
            assign above_q = cur_word[i+1];
        end
        shift_bit_cell u_cell (
            .sel      (sel),
            .own_q    (cur_word[i]),
            .below_q  (below_q),
            .above_q  (above_q),
            .par_bit  (load_data[i]),
            .next_bit (next_word[i])
        );
    end

    word_store #(.WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .clr       (clr),
        .next_word (next_word),
        .cur_word  (cur_word)
    );

    assign word_q = cur_word;
endmodule

// File: rtl/dual_shift_word_checker.sv
module dual_shift_word_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr,
    input logic [1:0]       mode,
    input logic             arith_sel,
    input logic             ser_in,
    input logic [WIDTH-1:0] load_data,
    input logic [WIDTH-1:0] word_q
);
    assert_clear_zero_R1: assert property (@(posedge clk)
        clr |=> (word_q == '0));

    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (clr)
        (mode == 2'b00) |=> $stable(word_q));

    assert_up_shift_R3: assert property (@(posedge clk) disable iff (clr)
        (mode == 2'b01) |=> (word_q == {$past(word_q[WIDTH-2:0]), $past(ser_in)}));

    assert_down_logical_R4: assert property (@(posedge clk) disable iff (clr)
        (mode == 2'b10 && !arith_sel) |=> (word_q == {1'b0, $past(word_q[WIDTH-1:1])}));

    assert_down_arith_R5: assert property (@(posedge clk) disable iff (clr)
        (mode == 2'b10 && arith_sel) |=>
            (word_q == {$past(word_q[WIDTH-1]), $past(word_q[WIDTH-1:1])}));

    assert_load_word_R6: assert property (@(posedge clk) disable iff (clr)
        (mode == 2'b11) |=> (word_q == $past(load_data)));
endmodule

bind dual_shift_word dual_shift_word_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .clr       (clr),
    .mode      (mode),
    .arith_sel (arith_sel),
    .ser_in    (ser_in),
    .load_data (load_data),
    .word_q    (word_q)
);

// File: tb/dual_shift_word_test.sv
module dual_shift_word_test;
    localparam int W          = 4;
    localparam int SPAN       = 1 << W;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         clr;
    logic [1:0]   mode;
    logic         arith_sel;
    logic         ser_in;
    logic [W-1:0] load_data;
    logic [W-1:0] word_q;

    int vectors = 0;
    int misses  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_shift_word #(.WIDTH(W)) uut (
        .clk       (clk),
        .clr       (clr),
        .mode      (mode),
        .arith_sel (arith_sel),
        .ser_in    (ser_in),
        .load_data (load_data),
        .word_q    (word_q)
    );

    task automatic step(input logic c, input logic [1:0] m, input logic a,
                        input logic s, input logic [W-1:0] d);
        @(negedge clk);
        clr = c; mode = m; arith_sel = a; ser_in = s; load_data = d;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [W-1:0] exp);
        vectors++;
        if (word_q !== exp) begin
            misses++;
            $display("FAIL %s: actual %b expected %b", tag, word_q, exp);
        end
    endtask

    function automatic int model(input int s, input int m, input int a, input int sr, input int d);
        case (m)
            0: return s;
            1: return ((s * 2) + sr) % SPAN;
            2: return (s / 2) + ((a != 0) ? (s & (SPAN / 2)) : 0);
            default: return d;
        endcase
    endfunction

    function automatic string tag_of(input int m, input int a);
        case (m)
            0: return "R2 R7 hold";
            1: return "R3 R7 move up";
            2: return (a != 0) ? "R5 R7 arith down" : "R4 R7 logical down";
            default: return "R6 R7 load";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        vectors++;
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        clr = 1'b1; mode = 2'b00; arith_sel = 1'b0; ser_in = 1'b0; load_data = '0;
        step(1'b1, 2'b11, 1'b1, 1'b1, 4'hF);
        check("R1 reset", '0);

        // Sweep: every start word, mode, fill choice, serial bit, and a spread of parallel words
        for (int s = 0; s < SPAN; s++) begin
            for (int m = 0; m < 4; m++) begin
                for (int a = 0; a < 2; a++) begin
                    for (int sr = 0; sr < 2; sr++) begin
                        for (int d = 0; d < SPAN; d += 5) begin
                            step(1'b0, 2'b11, 1'b0, 1'b0, W'(s));
                            step(1'b0, 2'(m), a[0], sr[0], W'(d));
                            check(tag_of(m, a), W'(model(s, m, a, sr, d)));
                        end
                    end
                end
            end
        end

        // R1: clear wins over every mode from a nonzero word
        for (int m = 0; m < 4; m++) begin
            step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1011);
            step(1'b1, 2'(m), 1'b1, 1'b1, 4'b0111);
            check("R1 clear priority", '0);
        end

        // R8: mid-cycle input changes do not reach the output before the edge
        step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1010);
        @(negedge clk);
        mode = 2'b11; load_data = 4'b0101; ser_in = 1'b1; arith_sel = 1'b1;
        #(CLK_PERIOD/4);
        check("R8 between edges", 4'b1010);
        load_data = 4'b0110;
        #(CLK_PERIOD/8);
        check("R8 between edges", 4'b1010);
        @(posedge clk);
        #1;
        check("R6 R8 after edge", 4'b0110);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule